// File: doc/BRIEF.md
# Reset Cause Collector

This block takes reset-cause events from seven places: the power-on reset itself, an external reset pin, a watchdog, a temperature sensor, a JTAG instruction update, a software system-reset request and a core lockup indication. Each event passes through its own gate. The watchdog and temperature gates use a keyed multi-bit mask field, and the lockup gate uses a single enable bit. An event that passes its gate raises a one-cycle system reset request. Alongside the request the block reports whether that reset must be cold or may be warm.

Every cause that passes its gate also sets a write-1-to-clear flag in a status word. A watchdog event that arrives while the watchdog is masked leaves a sticky marker instead, and only the hardware reset clears that marker. The control word also holds a self-clearing command bit that asks for a core-only reset.

Software reaches both words through a small write/read port with one address bit. Sequencing the resets is left to the blocks that consume these outputs.

Top module: `rstcause_top`

## Requirements
- R1: After rst_n is released, the control word (addr 0) reads 0x02A, the status word (addr 1) reads 0x001 (only the power-on flag, bit 0), and sys_rst_req, rst_cold and core_rst_req are all 0.
- R2: The watchdog mask is control bits [3:0]. Only the value 0x5 blocks the watchdog. 0xA (the default) and any other value let evt_wdog request a reset.
- R3: The temperature mask is control bits [6:4]. Only the value 0x5 blocks evt_temp. 0x2 (the default) and any other value let it request a reset.
- R4: A watchdog event that arrives while the watchdog is masked requests no reset and sets no cause flag. It does set the read-only status bit 9, which stays set through every register write and is cleared only by rst_n.
- R5: The status cause flags are: bit 1 external pin, bit 2 watchdog, bit 3 temperature, bit 4 JTAG, bit 5 software request, bit 6 lockup, and bit 0 power-on. A cause that passes its gate sets its flag at the next clock edge. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R6: Status bit 8 (warm-boot marker) is a plain read/write bit. It takes wdata[8] on every status write and does not change otherwise.
- R7: Control bit 9 is the core reset command and drives core_rst_req. Writing it as 1 sets it, and writing it as 0 has no effect. core_rst_done clears it. If both happen in the same cycle, the write wins.
- R8: evt_lockup requests a reset only while control bit 7 (lockup enable) is 1.
- R9: A JTAG cause is recorded only when jtag_ir_upd is 1 and jtag_ir equals the EXTEST code 4'h0 or the HIGHZ code 4'h7.
- R10: sys_rst_req is 1 in the cycle after any cause passes its gate. In that same cycle rst_cold is 1 if any cold-class cause (external pin, temperature, JTAG) fired or if control bit 8 (warm enable) is 0. rst_cold is 0 when only warm-class causes (watchdog, software request, lockup) fired and warm enable is 1.
- R11: Control bits [8:0] take wdata[8:0] on a write to addr 0. rdata returns the addressed word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware (power-on) reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control word, 1 = status word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed word |
| evt_ext | input | 1 | External reset pin event |
| evt_wdog | input | 1 | Watchdog timeout event |
| evt_temp | input | 1 | Temperature sensor event |
| jtag_ir | input | IR_W | Current JTAG instruction code |
| jtag_ir_upd | input | 1 | JTAG instruction update strobe |
| evt_swreq | input | 1 | Software system-reset request |
| evt_lockup | input | 1 | Core lockup indication |
| core_rst_done | input | 1 | Core-only reset has completed |
| sys_rst_req | output | 1 | One-cycle system reset request |
| rst_cold | output | 1 | Class of the current request: 1 cold, 0 warm |
| core_rst_req | output | 1 | Core-only reset command level |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a watchdog event setting its cause flag while software writes 1 to that same flag. The second pair is a software write of the core command while core_rst_done arrives. The bench drives each pair together on one negative edge and reads the word back afterwards. The flag and the command must both remain set. It also fires a warm-class cause and a cold-class cause in one cycle, and checks that the cold class wins.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int NSRC      = 6;
  // control word fields
  localparam int WM_LO     = 0;
  localparam int WM_W      = 4;
  localparam int TM_LO     = 4;
  localparam int TM_W      = 3;
  localparam int B_LOCKEN  = 7;
  localparam int B_WARMEN  = 8;
  localparam int B_COREGO  = 9;
  localparam int CTRL_USED = 10;
  localparam logic [WM_W-1:0] WDOG_OPEN = 4'hA;
  localparam logic [WM_W-1:0] WDOG_SHUT = 4'h5;
  localparam logic [TM_W-1:0] TEMP_OPEN = 3'h2;
  localparam logic [TM_W-1:0] TEMP_SHUT = 3'h5;
  // status word fields
  localparam int S_POR     = 0;
  localparam int S_CAUSE   = 1;
  localparam int S_WBOOT   = 8;
  localparam int S_WHELD   = 9;
  localparam int STAT_USED = 10;

  // bit k of this vector maps to status bit S_CAUSE+k
  typedef struct packed {
    logic lockup;
    logic swreq;
    logic jtag;
    logic temp;
    logic wdog;
    logic ext;
  } src_vec_t;

  // causes that may be served by a warm reset
  localparam logic [NSRC-1:0] WARM_CLASS = 6'b110010;
endpackage

// File: rtl/rsc_key_gate.sv
module rsc_key_gate #(
  parameter int             W    = 4,
  parameter logic [W-1:0]   SHUT = '0
) (
  input  logic [W-1:0] field,
  input  logic         evt,
  output logic         pass,
  output logic         held
);
  logic shut;

  always_comb begin
    shut = (field == SHUT);
    pass = evt & ~shut;
    held = evt &  shut;
  end
endmodule

// File: rtl/rsc_ctrl_reg.sv
module rsc_ctrl_reg
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              core_done,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] CTRL_RST =
    (DATA_W'(TEMP_OPEN) << TM_LO) | (DATA_W'(WDOG_OPEN) << WM_LO);

  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_en;
  wire               unused_hi = ^wdata[DATA_W-1:CTRL_USED];

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = wr_ctrl | core_done;
    if (wr_ctrl) ctrl_d[B_WARMEN:0] = wdata[B_WARMEN:0];
    if (wr_ctrl && wdata[B_COREGO]) ctrl_d[B_COREGO] = 1'b1;
    else if (core_done)             ctrl_d[B_COREGO] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   cause_set,
  input  logic              wdog_held,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] STAT_RST = DATA_W'(1) << S_POR;

  logic [DATA_W-1:0] stat_d;
  logic              stat_en;
  wire               unused_hi = ^{wdata[DATA_W-1:STAT_USED], wdata[S_WBOOT-1:S_CAUSE+NSRC]};

  always_comb begin
    stat_d  = stat_q;
    stat_en = wr_stat | (|cause_set) | wdog_held;
    if (wr_stat) begin
      stat_d[S_CAUSE+NSRC-1:0] = stat_q[S_CAUSE+NSRC-1:0] & ~wdata[S_CAUSE+NSRC-1:0];
      stat_d[S_WBOOT]          = wdata[S_WBOOT];
    end
    stat_d[S_CAUSE +: NSRC] = stat_d[S_CAUSE +: NSRC] | cause_set;
    if (wdog_held) stat_d[S_WHELD] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_RST;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/rstcause_top.sv
module rstcause_top
  import rsc_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] IR_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] IR_HIGHZ  = 4'h7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              evt_ext,
  input  logic              evt_wdog,
  input  logic              evt_temp,
  input  logic [IR_W-1:0]   jtag_ir,
  input  logic              jtag_ir_upd,
  input  logic              evt_swreq,
  input  logic              evt_lockup,
  input  logic              core_rst_done,
  output logic              sys_rst_req,
  output logic              rst_cold,
  output logic              core_rst_req
);
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] stat_word;
  logic              wr_ctrl, wr_stat;
  logic              wdog_pass, wdog_held, temp_pass, unused_temp_held;
  src_vec_t          qual;
  logic              req_d, cold_d;
  wire               unused_ctrl = ^ctrl_word[DATA_W-1:CTRL_USED];

  always_comb begin
    wr_ctrl = wr_en & ~addr;
    wr_stat = wr_en &  addr;
  end

  rsc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .core_done(core_rst_done), .ctrl_q(ctrl_word)
  );

  rsc_key_gate #(.W(WM_W), .SHUT(WDOG_SHUT)) u_wdog_gate (
    .field(ctrl_word[WM_LO +: WM_W]), .evt(evt_wdog),
    .pass(wdog_pass), .held(wdog_held)
  );

  rsc_key_gate #(.W(TM_W), .SHUT(TEMP_SHUT)) u_temp_gate (
    .field(ctrl_word[TM_LO +: TM_W]), .evt(evt_temp),
    .pass(temp_pass), .held(unused_temp_held)
  );

  always_comb begin
    qual.ext    = evt_ext;
    qual.wdog   = wdog_pass;
    qual.temp   = temp_pass;
    qual.jtag   = jtag_ir_upd & ((jtag_ir == IR_EXTEST) | (jtag_ir == IR_HIGHZ));
    qual.swreq  = evt_swreq;
    qual.lockup = evt_lockup & ctrl_word[B_LOCKEN];
    req_d       = |qual;
    cold_d      = req_d & ((|(qual & ~WARM_CLASS)) | ~ctrl_word[B_WARMEN]);
  end

  rsc_status_reg #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(wdata),
    .cause_set(qual), .wdog_held(wdog_held), .stat_q(stat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req <= 1'b0;
      rst_cold    <= 1'b0;
    end else begin
      sys_rst_req <= req_d;
      rst_cold    <= cold_d;
    end
  end

  always_comb begin
    rdata        = addr ? stat_word : ctrl_word;
    core_rst_req = ctrl_word[B_COREGO];
  end
endmodule

// File: rtl/rstcause_chk.sv
module rstcause_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr,
  input logic [DATA_W-1:0] wdata,
  input logic              evt_ext,
  input logic              evt_wdog,
  input logic              evt_temp,
  input logic              jtag_ir_upd,
  input logic              evt_swreq,
  input logic              evt_lockup,
  input logic              core_rst_done,
  input logic              sys_rst_req,
  input logic              rst_cold,
  input logic              core_rst_req,
  input logic [DATA_W-1:0] ctrl_word,
  input logic [DATA_W-1:0] stat_word
);
  wire unused_chk = ^{wdata, ctrl_word, stat_word};

  AST_HELD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[9] |=> stat_word[9]); // R4

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (|stat_word[6:1])); // R5

  AST_LOCKUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lockup && !ctrl_word[7] && !evt_ext && !evt_wdog && !evt_temp &&
     !jtag_ir_upd && !evt_swreq) |=> !sys_rst_req); // R8

  AST_COLD_NO_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[8] && (evt_ext || evt_wdog || evt_temp || jtag_ir_upd ||
     evt_swreq || evt_lockup)) |=> (!sys_rst_req || rst_cold)); // R10

  AST_CORE_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_req && core_rst_done && !(wr_en && !addr && wdata[9]))
    |=> !core_rst_req); // R7

  AST_WBOOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr) |=> $stable(stat_word[8])); // R6
endmodule

bind rstcause_top rstcause_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rstcause_top_test.sv
module rstcause_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, addr;
  logic [31:0] wdata, rdata;
  logic        evt_ext, evt_wdog, evt_temp, jtag_ir_upd, evt_swreq, evt_lockup;
  logic [3:0]  jtag_ir;
  logic        core_rst_done, sys_rst_req, rst_cold, core_rst_req;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rstcause_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .evt_ext(evt_ext), .evt_wdog(evt_wdog), .evt_temp(evt_temp), .jtag_ir(jtag_ir),
    .jtag_ir_upd(jtag_ir_upd), .evt_swreq(evt_swreq), .evt_lockup(evt_lockup),
    .core_rst_done(core_rst_done), .sys_rst_req(sys_rst_req), .rst_cold(rst_cold),
    .core_rst_req(core_rst_req)
  );

  // {ctrl[8:0], events{lockup,sw,jtag,temp,wdog,ext}, exp_req, exp_cold, exp_flags[6:1]}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {9'h02A, 6'b000010, 1'b1, 1'b1, 6'b000010},  // R2 R10 default mask, warm off
    {9'h12A, 6'b000010, 1'b1, 1'b0, 6'b000010},  // R10 warm
    {9'h12A, 6'b010000, 1'b1, 1'b0, 6'b010000},  // R5 sw
    {9'h12A, 6'b000001, 1'b1, 1'b1, 6'b000001},  // R5 ext cold
    {9'h125, 6'b000010, 1'b0, 1'b0, 6'b000000},  // R2 R4 masked wdog
    {9'h15A, 6'b000100, 1'b0, 1'b0, 6'b000000},  // R3 masked temp
    {9'h12A, 6'b000100, 1'b1, 1'b1, 6'b000100},  // R3 temp open
    {9'h12A, 6'b100000, 1'b0, 1'b0, 6'b000000},  // R8 lockup disabled
    {9'h1AA, 6'b100000, 1'b1, 1'b0, 6'b100000},  // R8 lockup enabled
    {9'h12A, 6'b001000, 1'b1, 1'b1, 6'b001000},  // R9 EXTEST
    {9'h12A, 6'b010010, 1'b1, 1'b0, 6'b010010},  // R10 two warm
    {9'h12A, 6'b010001, 1'b1, 1'b1, 6'b010001},  // R10 warm+cold
    {9'h123, 6'b000010, 1'b1, 1'b0, 6'b000010},  // R2 odd key
    {9'h17A, 6'b000100, 1'b1, 1'b1, 6'b000100}   // R3 odd key
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_evt(input logic [5:0] e);
    evt_ext = e[0]; evt_wdog = e[1]; evt_temp = e[2];
    jtag_ir_upd = e[3]; jtag_ir = 4'h0; evt_swreq = e[4]; evt_lockup = e[5];
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0;
    set_evt(6'b0); core_rst_done = 1'b0;
    do_reset();

    // R1 reset state
    rd(1'b0, v); check("R1 ctrl", v, 32'h02A);
    rd(1'b1, v); check("R1 status", v, 32'h001);
    check("R1 outputs", {29'b0, sys_rst_req, rst_cold, core_rst_req}, 32'h0);

    // R5 write 0 has no effect, write 1 clears POR
    wr(1'b1, 32'h0); rd(1'b1, v); check("R5 write0 keeps", v, 32'h001);
    wr(1'b1, 32'h1); rd(1'b1, v); check("R5 w1c por", v, 32'h000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, {23'b0, VEC[i][22:14]});
      wr(1'b1, 32'h07F);
      @(negedge clk); set_evt(VEC[i][13:8]);
      @(negedge clk); set_evt(6'b0);
      check($sformatf("R10 req vec%0d", i), {31'b0, sys_rst_req}, {31'b0, VEC[i][7]});
      check($sformatf("R10 cold vec%0d", i), {31'b0, rst_cold}, {31'b0, VEC[i][6]});
      rd(1'b1, v);
      check($sformatf("R5 flags vec%0d", i), {26'b0, v[6:1]}, {26'b0, VEC[i][5:0]});
      check($sformatf("R10 req drop vec%0d", i), {31'b0, sys_rst_req}, 32'h0);
    end

    // R4 sticky from masked watchdog survives writes
    rd(1'b1, v); check("R4 held set", {31'b0, v[9]}, 32'h1);
    wr(1'b1, 32'h3FF); rd(1'b1, v);
    check("R4 held after write", {31'b0, v[9]}, 32'h1);
    check("R6 wboot set", {31'b0, v[8]}, 32'h1);
    wr(1'b1, 32'h07F); rd(1'b1, v);
    check("R6 wboot cleared", {31'b0, v[8]}, 32'h0);

    // R9 non-matching code and no update strobe
    wr(1'b0, 32'h12A);
    @(negedge clk); jtag_ir = 4'h3; jtag_ir_upd = 1'b1;
    @(negedge clk); jtag_ir_upd = 1'b0;
    check("R9 other code", {31'b0, sys_rst_req}, 32'h0);
    @(negedge clk); jtag_ir = 4'h0; jtag_ir_upd = 1'b0;
    @(negedge clk);
    check("R9 no strobe", {31'b0, sys_rst_req}, 32'h0);
    @(negedge clk); jtag_ir = 4'h7; jtag_ir_upd = 1'b1;
    @(negedge clk); jtag_ir_upd = 1'b0;
    check("R9 HIGHZ", {30'b0, sys_rst_req, rst_cold}, 32'h3);
    rd(1'b1, v); check("R9 flag", {31'b0, v[4]}, 32'h1);

    // R5 same-cycle set and clear: set wins
    wr(1'b1, 32'h07F);
    @(negedge clk); evt_wdog = 1'b1; wr_en = 1'b1; addr = 1'b1; wdata = 32'h004;
    @(negedge clk); evt_wdog = 1'b0; wr_en = 1'b0; wdata = '0;
    rd(1'b1, v); check("R5 set beats clear", {31'b0, v[2]}, 32'h1);

    // R11 control field write and read
    wr(1'b0, 32'h1D3); rd(1'b0, v); check("R11 ctrl rw", v, 32'h1D3);

    // R7 core command
    wr(1'b0, 32'h22A); check("R7 core set", {31'b0, core_rst_req}, 32'h1);
    wr(1'b0, 32'h02A); check("R7 write0 ignored", {31'b0, core_rst_req}, 32'h1);
    @(negedge clk); core_rst_done = 1'b1; wr_en = 1'b1; addr = 1'b0; wdata = 32'h22A;
    @(negedge clk); core_rst_done = 1'b0; wr_en = 1'b0; wdata = '0;
    check("R7 write beats done", {31'b0, core_rst_req}, 32'h1);
    @(negedge clk); core_rst_done = 1'b1;
    @(negedge clk); core_rst_done = 1'b0;
    check("R7 done clears", {31'b0, core_rst_req}, 32'h0);

    // R1 R4 hardware reset clears sticky, leaves only POR
    do_reset();
    rd(1'b1, v); check("R4 R1 status after reset", v, 32'h001);
    rd(1'b0, v); check("R1 ctrl after reset", v, 32'h02A);

    finish_up();
  end
endmodule